// File: doc/BRIEF.md
# Serial Transmit DMA Status Controller

This block sits between a memory-read DMA path and a 16-bit transmit FIFO that feeds a serial transmitter. It fits each memory word to the FIFO width. A byte transfer is zero-padded. A half-word transfer passes through unchanged. A word transfer is cut to its low half. The block moves words over valid/ready handshakes on both sides and counts them down from a transfer count loaded by a descriptor-fetch strobe. It also keeps completion and underflow status for each work block.

When DMA is switched off, the block raises a one-cycle per-word interrupt each time the transmitter starts a word. When DMA is on, a DMA interrupt is raised from status bits. Bit 0 reports completion and bit 1 reports an underflow error, and each bit counts only while its enable is set. A third status bit is a per-block underflow flag. It is set on every underflow and is cleared only by the next descriptor fetch. The host clears bits 0 and 1 by writing ones to them.

A small state machine tracks the work block. It has three states: ST_IDLE (after reset, no block), ST_XFER (block active, count not yet zero) and ST_DONE (block finished). Its transitions are as follows:
- LOAD_RUN: any state goes to ST_XFER on a descriptor fetch with a nonzero count.
- LOAD_EMPTY: any state goes to ST_DONE on a descriptor fetch with a zero count.
- LAST_BEAT: ST_XFER goes to ST_DONE on the handshake that takes the count from 1 to 0.
- HOLD: ST_IDLE and ST_DONE stay where they are until the next fetch.

Top module: `sptx_dma_ctrl`

## Requirements
- R1: With `cfg_dma_en` low, each cycle with `word_start` high gives `word_irq` high in the following cycle, for exactly one cycle. With `cfg_dma_en` high, `word_irq` stays low.
- R2: Size code 2'b00 (byte): `fifo_data` = {8'h00, `mem_data`[7:0]}.
- R3: Size codes 2'b01 (half-word) and 2'b11 (reserved): `fifo_data` = `mem_data`[15:0].
- R4: Size code 2'b10 (word): `fifo_data` = `mem_data`[15:0]. The upper 16 memory bits are dropped.
- R5: `mem_ready` equals `fifo_ready` and `fifo_valid` equals `mem_valid`, but only while a block is active and `cfg_dma_en` is high. Otherwise both are low. A transfer happens only when `mem_valid`, `mem_ready`, `fifo_valid` and `fifo_ready` are all high.
- R6: A descriptor fetch with count N > 0 allows exactly N transfers. After the Nth, `mem_ready` stays low.
- R7: When a block completes and `cfg_done_ie` is high, `status`[0] is set in the cycle after completion. A block completes either on its final transfer or on a descriptor fetch with count 0. With `cfg_done_ie` low, completion leaves `status`[0] unchanged.
- R8: `tx_underflow` with `cfg_err_ie` high sets `status`[1] in the next cycle. With `cfg_err_ie` low, `status`[1] is unchanged.
- R9: `status`[2] is set on every `tx_underflow`, whatever the enables. It stays set until a descriptor fetch clears it. An underflow in the same cycle as the fetch leaves it set.
- R10: `stat_clr`[0] clears `status`[0] and `stat_clr`[1] clears `status`[1] in the next cycle. A set condition in the same cycle wins over the clear.
- R11: `dma_irq` = (`status`[0] & `cfg_done_ie`) | (`status`[1] & `cfg_err_ie`), with no added latency.
- R12: After reset, `status`, `word_irq`, `dma_irq`, `mem_ready` and `fifo_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dma_en | input | 1 | DMA enable |
| cfg_done_ie | input | 1 | Completion interrupt enable |
| cfg_err_ie | input | 1 | Underflow error interrupt enable |
| cfg_size | input | 2 | Transfer size code |
| desc_load | input | 1 | Descriptor fetch strobe |
| desc_count | input | 16 | Transfer count for the new block |
| mem_valid | input | 1 | Memory read data valid |
| mem_data | input | 32 | Memory read data |
| mem_ready | output | 1 | Memory data accepted |
| fifo_valid | output | 1 | FIFO write request |
| fifo_data | output | 16 | FIFO write data |
| fifo_ready | input | 1 | FIFO not full |
| word_start | input | 1 | Transmitter began a word |
| tx_underflow | input | 1 | Serializer underflow pulse |
| stat_clr | input | 2 | Write-one-to-clear for status bits 0 and 1 |
| status | output | 3 | {underflow flag, error, done} |
| word_irq | output | 1 | Per-word interrupt (DMA off) |
| dma_irq | output | 1 | DMA interrupt |

## Verification
The width path is driven with memory words whose upper bytes and upper half differ from their low bits. This makes it possible to tell zero-padding from pass-through and from truncation, under all four size codes, including the reserved one. Blocks are run with counts of three, one and zero. These counts separate the final-beat completion from the immediate completion on an empty load, and they show that the handshake stops after exactly N beats. The underflow pulse is applied with the error enable on and off, alone and together with a fetch or a host clear. This shows which of the two error bits each path touches and how the set-over-clear priority works.

// File: rtl/sptx_pkg.sv
package sptx_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_XFER = 2'b01,
        ST_DONE = 2'b10
    } blk_state_e;

    localparam int STAT_DONE = 0;
    localparam int STAT_ERR  = 1;
    localparam int STAT_UFL  = 2;
    localparam int STAT_W    = 3;

endpackage

// File: rtl/sptx_width_adapt.sv
module sptx_width_adapt
    import sptx_pkg::*;
#(
    parameter int MEM_W  = 32,
    parameter int FIFO_W = 16
) (
    input  logic [1:0]        size,
    input  logic [MEM_W-1:0]  mem_data,
    output logic [FIFO_W-1:0] fifo_data
);

    localparam int BYTE_W  = 8;
    localparam int HALF_NM = 16;
    localparam int LIM_W   = (MEM_W < FIFO_W) ? MEM_W : FIFO_W;
    localparam int HALF_W  = (HALF_NM < LIM_W) ? HALF_NM : LIM_W;
    localparam int WORD_W  = LIM_W;

    logic [FIFO_W-1:0] byte_path;
    logic [FIFO_W-1:0] half_path;
    logic [FIFO_W-1:0] word_path;

    generate
        if (FIFO_W > BYTE_W) begin : g_byte_pad
            assign byte_path = {{(FIFO_W-BYTE_W){1'b0}}, mem_data[BYTE_W-1:0]};
        end else begin : g_byte_full
            assign byte_path = mem_data[FIFO_W-1:0];
        end

        if (FIFO_W > HALF_W) begin : g_half_pad
            assign half_path = {{(FIFO_W-HALF_W){1'b0}}, mem_data[HALF_W-1:0]};
        end else begin : g_half_full
            assign half_path = mem_data[HALF_W-1:0];
        end

        if (FIFO_W > WORD_W) begin : g_word_pad
            assign word_path = {{(FIFO_W-WORD_W){1'b0}}, mem_data[WORD_W-1:0]};
        end else begin : g_word_trunc
            assign word_path = mem_data[WORD_W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (size_e'(size))
            SZ_BYTE: fifo_data = byte_path;
            SZ_WORD: fifo_data = word_path;
            SZ_HALF: fifo_data = half_path;
            SZ_RSVD: fifo_data = half_path;
            default: fifo_data = half_path;
        endcase
    end

endmodule

// File: rtl/sptx_blk_fsm.sv
module sptx_blk_fsm
    import sptx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_en,
    input  logic             desc_load,
    input  logic [CNT_W-1:0] desc_count,
    input  logic             mem_valid,
    input  logic             fifo_ready,
    output logic             mem_ready,
    output logic             fifo_valid,
    output logic             blk_done
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    blk_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             active;
    logic             beat;
    logic             last_beat;
    logic             load_empty;

    assign active     = (state_q == ST_XFER) && dma_en;
    assign beat       = active && mem_valid && fifo_ready;
    assign last_beat  = beat && (cnt_q == CNT_ONE);
    assign load_empty = desc_load && (desc_count == CNT_ZERO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (desc_load) begin
            cnt_d   = desc_count;
            state_d = load_empty ? ST_DONE : ST_XFER;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_XFER: begin
                    if (beat) begin
                        cnt_d = cnt_q - CNT_ONE;
                    end
                    state_d = last_beat ? ST_DONE : ST_XFER;
                end
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_ready  = active && fifo_ready;
        fifo_valid = active && mem_valid;
        blk_done   = desc_load ? load_empty : last_beat;
    end

endmodule

// File: rtl/sptx_status.sv
module sptx_status
    import sptx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_ie,
    input  logic              err_ie,
    input  logic              blk_done,
    input  logic              underflow,
    input  logic              desc_load,
    input  logic [1:0]        clr,
    output logic [STAT_W-1:0] status,
    output logic              dma_irq
);

    logic done_q, err_q, ufl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            ufl_q  <= 1'b0;
        end else begin
            if (blk_done && done_ie) begin
                done_q <= 1'b1;
            end else if (clr[STAT_DONE]) begin
                done_q <= 1'b0;
            end

            if (underflow && err_ie) begin
                err_q <= 1'b1;
            end else if (clr[STAT_ERR]) begin
                err_q <= 1'b0;
            end

            if (underflow) begin
                ufl_q <= 1'b1;
            end else if (desc_load) begin
                ufl_q <= 1'b0;
            end
        end
    end

    always_comb begin
        status            = '0;
        status[STAT_DONE] = done_q;
        status[STAT_ERR]  = err_q;
        status[STAT_UFL]  = ufl_q;
        dma_irq           = (done_q && done_ie) || (err_q && err_ie);
    end

endmodule

// File: rtl/sptx_dma_ctrl.sv
module sptx_dma_ctrl
    import sptx_pkg::*;
#(
    parameter int MEM_W  = 32,
    parameter int FIFO_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dma_en,
    input  logic              cfg_done_ie,
    input  logic              cfg_err_ie,
    input  logic [1:0]        cfg_size,
    input  logic              desc_load,
    input  logic [CNT_W-1:0]  desc_count,
    input  logic              mem_valid,
    input  logic [MEM_W-1:0]  mem_data,
    output logic              mem_ready,
    output logic              fifo_valid,
    output logic [FIFO_W-1:0] fifo_data,
    input  logic              fifo_ready,
    input  logic              word_start,
    input  logic              tx_underflow,
    input  logic [1:0]        stat_clr,
    output logic [STAT_W-1:0] status,
    output logic              word_irq,
    output logic              dma_irq
);

    logic blk_done;
    logic word_irq_q;

    sptx_width_adapt #(
        .MEM_W  (MEM_W),
        .FIFO_W (FIFO_W)
    ) u_adapt (
        .size      (cfg_size),
        .mem_data  (mem_data),
        .fifo_data (fifo_data)
    );

    sptx_blk_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .dma_en     (cfg_dma_en),
        .desc_load  (desc_load),
        .desc_count (desc_count),
        .mem_valid  (mem_valid),
        .fifo_ready (fifo_ready),
        .mem_ready  (mem_ready),
        .fifo_valid (fifo_valid),
        .blk_done   (blk_done)
    );

    sptx_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_ie   (cfg_done_ie),
        .err_ie    (cfg_err_ie),
        .blk_done  (blk_done),
        .underflow (tx_underflow),
        .desc_load (desc_load),
        .clr       (stat_clr),
        .status    (status),
        .dma_irq   (dma_irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_irq_q <= 1'b0;
        end else begin
            word_irq_q <= word_start && !cfg_dma_en;
        end
    end

    assign word_irq = word_irq_q;

endmodule

// File: rtl/sptx_dma_ctrl_chk.sv
module sptx_dma_ctrl_chk #(
    parameter int MEM_W  = 32,
    parameter int FIFO_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_dma_en,
    input logic              cfg_done_ie,
    input logic              cfg_err_ie,
    input logic [1:0]        cfg_size,
    input logic              desc_load,
    input logic [CNT_W-1:0]  desc_count,
    input logic              mem_valid,
    input logic [MEM_W-1:0]  mem_data,
    input logic              mem_ready,
    input logic              fifo_valid,
    input logic [FIFO_W-1:0] fifo_data,
    input logic              fifo_ready,
    input logic              word_start,
    input logic              tx_underflow,
    input logic [1:0]        stat_clr,
    input logic [2:0]        status,
    input logic              word_irq,
    input logic              dma_irq
);

    // R1
    p_word_irq_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (word_start && !cfg_dma_en) |=> word_irq);

    p_no_word_irq_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_start || cfg_dma_en) |=> !word_irq);

    // R2
    p_byte_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_valid && cfg_size == 2'b00) |->
            (fifo_data[FIFO_W-1:8] == '0 && fifo_data[7:0] == mem_data[7:0]));

    // R5
    p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dma_en |-> (!mem_ready && !fifo_valid));

    p_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |-> (fifo_valid && fifo_ready));

    // R7
    p_empty_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_load && desc_count == '0 && cfg_done_ie) |=> status[0]);

    // R8
    p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_underflow && cfg_err_ie) |=> status[1]);

    // R9
    p_ufl_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underflow |=> status[2]);

    p_ufl_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_load && !tx_underflow) |=> !status[2]);

    // R11
    p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1:0] == 2'b00) |-> !dma_irq);

    // R12
    p_reset_quiet_r12: assert property (@(posedge clk)
        !rst_n |-> (status == 3'b000 && !word_irq && !dma_irq));

    logic unused_ok;
    assign unused_ok = ^{mem_data[MEM_W-1:8], stat_clr};

endmodule

bind sptx_dma_ctrl sptx_dma_ctrl_chk #(
    .MEM_W  (MEM_W),
    .FIFO_W (FIFO_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_dma_en   (cfg_dma_en),
    .cfg_done_ie  (cfg_done_ie),
    .cfg_err_ie   (cfg_err_ie),
    .cfg_size     (cfg_size),
    .desc_load    (desc_load),
    .desc_count   (desc_count),
    .mem_valid    (mem_valid),
    .mem_data     (mem_data),
    .mem_ready    (mem_ready),
    .fifo_valid   (fifo_valid),
    .fifo_data    (fifo_data),
    .fifo_ready   (fifo_ready),
    .word_start   (word_start),
    .tx_underflow (tx_underflow),
    .stat_clr     (stat_clr),
    .status       (status),
    .word_irq     (word_irq),
    .dma_irq      (dma_irq)
);

// File: tb/sptx_dma_ctrl_tb.sv
module sptx_dma_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 5000;
    localparam int NVEC       = 7;

    // {size, mem_data, expected fifo_data}
    localparam logic [49:0] VEC [NVEC] = '{
        {2'b00, 32'hDEADBEEF, 16'h00EF},
        {2'b00, 32'h123456FF, 16'h00FF},
        {2'b01, 32'hCAFE1234, 16'h1234},
        {2'b11, 32'hABCD8001, 16'h8001},
        {2'b10, 32'h89ABCDEF, 16'hCDEF},
        {2'b10, 32'h0000FFFF, 16'hFFFF},
        {2'b01, 32'hFFFF0000, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_dma_en = 1'b0;
    logic        cfg_done_ie = 1'b0;
    logic        cfg_err_ie = 1'b0;
    logic [1:0]  cfg_size = 2'b01;
    logic        desc_load = 1'b0;
    logic [15:0] desc_count = '0;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_data = '0;
    logic        mem_ready;
    logic        fifo_valid;
    logic [15:0] fifo_data;
    logic        fifo_ready = 1'b0;
    logic        word_start = 1'b0;
    logic        tx_underflow = 1'b0;
    logic [1:0]  stat_clr = 2'b00;
    logic [2:0]  status;
    logic        word_irq;
    logic        dma_irq;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sptx_dma_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_dma_en   (cfg_dma_en),
        .cfg_done_ie  (cfg_done_ie),
        .cfg_err_ie   (cfg_err_ie),
        .cfg_size     (cfg_size),
        .desc_load    (desc_load),
        .desc_count   (desc_count),
        .mem_valid    (mem_valid),
        .mem_data     (mem_data),
        .mem_ready    (mem_ready),
        .fifo_valid   (fifo_valid),
        .fifo_data    (fifo_data),
        .fifo_ready   (fifo_ready),
        .word_start   (word_start),
        .tx_underflow (tx_underflow),
        .stat_clr     (stat_clr),
        .status       (status),
        .word_irq     (word_irq),
        .dma_irq      (dma_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    initial begin
        for (int c = 0; c < WDOG_LIMIT; c++) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int beats;
        tick();
        // R12: reset state
        chk("R12 status", 32'(status), 32'h0);
        chk("R12 irqs", {30'h0, word_irq, dma_irq}, 32'h0);
        chk("R12 handshake", {30'h0, mem_ready, fifo_valid}, 32'h0);
        rst_n = 1'b1;
        tick();

        // R1: per-word interrupt with DMA off
        word_start = 1'b1;
        tick();
        word_start = 1'b0;
        chk("R1 word_irq pulse", 32'(word_irq), 32'h1);
        tick();
        chk("R1 word_irq one cycle", 32'(word_irq), 32'h0);
        cfg_dma_en = 1'b1;
        word_start = 1'b1;
        tick();
        word_start = 1'b0;
        chk("R1 no word_irq with DMA on", 32'(word_irq), 32'h0);

        // Active block with FIFO full: no beats consumed, data path visible
        desc_load  = 1'b1;
        desc_count = 16'hFFFF;
        tick();
        desc_load  = 1'b0;
        mem_valid  = 1'b1;
        fifo_ready = 1'b0;
        #1;
        chk("R5 full fifo blocks ready", 32'(mem_ready), 32'h0);
        chk("R5 fifo_valid follows mem_valid", 32'(fifo_valid), 32'h1);

        // Width-path table (R2, R3, R4)
        for (int i = 0; i < NVEC; i++) begin
            cfg_size = VEC[i][49:48];
            mem_data = VEC[i][47:16];
            #1;
            if (VEC[i][49:48] == 2'b00)
                chk("R2 byte pad", 32'(fifo_data), 32'(VEC[i][15:0]));
            else if (VEC[i][49:48] == 2'b10)
                chk("R4 word truncate", 32'(fifo_data), 32'(VEC[i][15:0]));
            else
                chk("R3 half/reserved pass", 32'(fifo_data), 32'(VEC[i][15:0]));
        end

        // R5: DMA off silences the handshake
        cfg_dma_en = 1'b0;
        fifo_ready = 1'b1;
        #1;
        chk("R5 DMA off", {30'h0, mem_ready, fifo_valid}, 32'h0);
        cfg_dma_en = 1'b1;
        tick();

        // R6, R7: block of three
        cfg_done_ie = 1'b1;
        desc_load   = 1'b1;
        desc_count  = 16'd3;
        fifo_ready  = 1'b0;
        tick();
        desc_load  = 1'b0;
        fifo_ready = 1'b1;
        beats = 0;
        for (int k = 0; k < 8; k++) begin
            #1;
            if (mem_ready && mem_valid) beats++;
            tick();
        end
        chk("R6 beat count", 32'(beats), 32'd3);
        chk("R6 ready low after block", 32'(mem_ready), 32'h0);
        chk("R7 done after last beat", 32'(status[0]), 32'h1);
        chk("R11 irq from done", 32'(dma_irq), 32'h1);

        // R10: host clear of done
        stat_clr = 2'b01;
        tick();
        stat_clr = 2'b00;
        chk("R10 clear done", 32'(status[0]), 32'h0);
        chk("R11 irq cleared", 32'(dma_irq), 32'h0);

        // R7: empty block completes at once
        desc_load  = 1'b1;
        desc_count = 16'd0;
        tick();
        desc_load = 1'b0;
        chk("R7 zero count done", 32'(status[0]), 32'h1);
        chk("R6 zero count no ready", 32'(mem_ready), 32'h0);
        stat_clr = 2'b01;
        tick();
        stat_clr = 2'b00;

        // R7: completion enable off
        cfg_done_ie = 1'b0;
        desc_load   = 1'b1;
        desc_count  = 16'd1;
        tick();
        desc_load = 1'b0;
        tick();
        tick();
        chk("R7 done masked", 32'(status[0]), 32'h0);

        // R8, R9: underflow with error enable off
        tx_underflow = 1'b1;
        tick();
        tx_underflow = 1'b0;
        chk("R8 err masked", 32'(status[1]), 32'h0);
        chk("R9 flag set", 32'(status[2]), 32'h1);

        // R8: error enable on
        cfg_err_ie   = 1'b1;
        tx_underflow = 1'b1;
        tick();
        tx_underflow = 1'b0;
        chk("R8 err set", 32'(status[1]), 32'h1);
        chk("R11 irq from err", 32'(dma_irq), 32'h1);
        cfg_err_ie = 1'b0;
        #1;
        chk("R11 irq masked", 32'(dma_irq), 32'h0);
        cfg_err_ie = 1'b1;

        // R10: set wins over clear
        stat_clr     = 2'b10;
        tx_underflow = 1'b1;
        tick();
        stat_clr     = 2'b00;
        tx_underflow = 1'b0;
        chk("R10 set beats clear", 32'(status[1]), 32'h1);
        stat_clr = 2'b10;
        tick();
        stat_clr = 2'b00;
        chk("R10 clear err", 32'(status[1]), 32'h0);
        chk("R9 flag survives host clear", 32'(status[2]), 32'h1);

        // R9: fetch clears flag; fetch plus underflow keeps it
        desc_load  = 1'b1;
        desc_count = 16'd0;
        tick();
        desc_load = 1'b0;
        chk("R9 fetch clears flag", 32'(status[2]), 32'h0);
        desc_load    = 1'b1;
        tx_underflow = 1'b1;
        tick();
        desc_load    = 1'b0;
        tx_underflow = 1'b0;
        chk("R9 fetch with underflow", 32'(status[2]), 32'h1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule